// File: doc/BRIEF.md
# Watchpoint Comparator and Event Unit

This block watches a running processor and turns what it sees into debug events. A bank of comparators looks at three sources. The first is the instruction fetch address. The second is the data bus access: address, value, direction and size. The third is a free-running cycle count. Each comparator is set to one kind of match. An instruction-address comparator can ignore a number of low address bits, so that one comparator covers an aligned window of code. A data-address comparator filters on the access direction. A data-value comparator looks at a byte, halfword or word and can be tied to one or two data-address comparators. A cycle comparator fires on one exact count.

Every comparator result is registered once. A set/clear latch gives a stateful resource: selected comparators set it and other comparators clear it. Two event combiners build a trigger event and an enable event from the comparators and the latch. An event is a constant, a single resource with optional inversion, or two resources, each with optional inversion, joined by AND, OR, XOR or NAND. All configuration is written through a single-cycle write port. Writes take effect on the next clock edge.

Top module: `wpt_event_unit`

## Requirements
- R1: After reset, every comparator is off. Both events are constant false and the latch is clear, so `cmp_match`, `latch_state`, `trig_evt` and `enab_evt` are all 0.
- R2: An instruction-address comparator (control kind field, bits [2:0], = 1) matches when `pc_valid` is high and `pc` equals the stored value. PC bit 0 is always ignored because fetches are halfword aligned.
- R3: The mask field (control bits [11:7]) gives the number of low address bits that are ignored in both the address and the stored value. The comparator then covers an aligned window of 2^mask bytes. This applies to instruction-address and data-address comparators.
- R4: A data-address comparator (kind = 2) matches on `bus_valid` and an address equal to the stored value. It never looks at `bus_data`. The access-mode field (bits [4:3]) selects the direction: 0 or 3 = either direction, 1 = reads only (`bus_write` = 0), 2 = writes only.
- R5: A data-value comparator (kind = 3) matches when `bus_valid` is high, the access mode accepts the direction, `bus_size` equals the size field (bits [6:5]: 0 byte, 1 halfword, 2 word), and the low 8, 16 or 32 bits of `bus_data` equal those of the stored value.
- R6: A data-value comparator can be linked to two address comparators. Link enable 0 is bit [12] and its index is bits [15:13]. Link enable 1 is bit [16] and its index is bits [19:17]. When at least one link is enabled, the value comparator matches only if an enabled, linked data-address comparator matches the same access. With no link enabled, the address plays no part in the match.
- R7: A cycle comparator (kind = 4) matches when `cyc_cnt` equals the stored value. Kinds 0, 5, 6 and 7 never match.
- R8: An event word has these fields: form [1:0], resource A [5:2], invert A [6], resource B [10:7], invert B [11], operation [13:12]. Form 0 gives 0, form 1 gives 1, and form 2 gives resource A XOR invert A. Resources 0..N-1 are the registered comparator matches, resource N is the latch, and any higher number reads as 0.
- R9: Form 3 joins the two inverted-as-configured resources. The operation field selects 0 = AND, 1 = OR, 2 = XOR, 3 = NAND.
- R10: The latch sets when a comparator in the set mask (bits [N-1:0] of the latch word) matches. It clears when a comparator in the clear mask (bits [8+N-1:8]) matches and no set comparator matches. Setting wins, including when one comparator is in both masks.
- R11: Every output reflects the inputs of the previous clock cycle, exactly one cycle later. Register map: comparator i has its value at 2i and its control at 2i+1. The trigger event is at 2N, the enable event at 2N+1 and the latch masks at 2N+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration word index |
| cfg_wdata | input | 32 | Configuration write data |
| pc_valid | input | 1 | Instruction fetch address is valid |
| pc | input | 32 | Instruction fetch address |
| bus_valid | input | 1 | Data access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_addr | input | 32 | Data access address |
| bus_data | input | 32 | Data access value |
| cyc_cnt | input | CYC_W | Cycle counter |
| cmp_match | output | NUM_CMP | Registered comparator matches |
| latch_state | output | 1 | Set/clear latch |
| trig_evt | output | 1 | Trigger event |
| enab_evt | output | 1 | Enable event |

## Verification
The hardest case to reach is a linked value match. It needs a value comparator and its linked address comparators to agree on one access, and the address comparator's direction filter can veto the match on its own. The stimulus first sets up two address comparators with opposite direction filters. It then links a byte-value comparator to both and sweeps reads and writes with matching and non-matching values at each address. Another hard case is the set/clear latch when one access hits both a set comparator and a clear comparator. The directed phase builds this on purpose and then runs a long random phase that mixes configuration writes and accesses drawn near the stored values.

// File: rtl/wpt_pkg.sv
package wpt_pkg;

    parameter int WORD_W = 32;
    parameter int MASK_W = 5;
    parameter int IDX_W  = 3;
    parameter int SEL_W  = 4;

    typedef enum logic [2:0] {
        KIND_OFF   = 3'd0,
        KIND_IADDR = 3'd1,
        KIND_DADDR = 3'd2,
        KIND_DVAL  = 3'd3,
        KIND_CYCLE = 3'd4
    } cmp_kind_e;

    typedef enum logic [1:0] {
        ACC_ANY = 2'd0,
        ACC_RD  = 2'd1,
        ACC_WR  = 2'd2
    } acc_mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic [1:0] {
        EVT_FALSE = 2'd0,
        EVT_TRUE  = 2'd1,
        EVT_ONE   = 2'd2,
        EVT_TWO   = 2'd3
    } evt_form_e;

    typedef enum logic [1:0] {
        OP_AND  = 2'd0,
        OP_OR   = 2'd1,
        OP_XOR  = 2'd2,
        OP_NAND = 2'd3
    } evt_op_e;

    typedef struct packed {
        logic [WORD_W-1:0] value;
        logic [2:0]        kind;
        logic [1:0]        acc;
        logic [1:0]        size;
        logic [MASK_W-1:0] mask;
        logic              l0_en;
        logic [IDX_W-1:0]  l0_idx;
        logic              l1_en;
        logic [IDX_W-1:0]  l1_idx;
    } cmp_cfg_t;

    typedef struct packed {
        logic [1:0]       form;
        logic [SEL_W-1:0] sel_a;
        logic             inv_a;
        logic [SEL_W-1:0] sel_b;
        logic             inv_b;
        logic [1:0]       op;
    } evt_cfg_t;

endpackage

// File: rtl/wpt_cfg_regs.sv
module wpt_cfg_regs
    import wpt_pkg::*;
#(
    parameter int NUM_CMP = 4,
    parameter int CFG_AW  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we_i,
    input  logic [CFG_AW-1:0]     addr_i,
    input  logic [WORD_W-1:0]     wdata_i,
    output cmp_cfg_t [NUM_CMP-1:0] cmp_cfg_o,
    output evt_cfg_t              trig_cfg_o,
    output evt_cfg_t              enab_cfg_o,
    output logic [NUM_CMP-1:0]    set_mask_o,
    output logic [NUM_CMP-1:0]    clr_mask_o
);

    localparam int TRIG_IDX  = 2 * NUM_CMP;
    localparam int ENAB_IDX  = 2 * NUM_CMP + 1;
    localparam int LATCH_IDX = 2 * NUM_CMP + 2;
    localparam int CLR_LSB   = 8;

    typedef struct packed {
        cmp_cfg_t [NUM_CMP-1:0] cmp;
        evt_cfg_t               trig;
        evt_cfg_t               enab;
        logic [NUM_CMP-1:0]     set_m;
        logic [NUM_CMP-1:0]     clr_m;
    } regs_t;

    regs_t st_d, st_q;

    function automatic evt_cfg_t unpack_evt(input logic [WORD_W-1:0] w);
        evt_cfg_t e;
        e.form  = w[1:0];
        e.sel_a = w[5:2];
        e.inv_a = w[6];
        e.sel_b = w[10:7];
        e.inv_b = w[11];
        e.op    = w[13:12];
        return e;
    endfunction

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            for (int i = 0; i < NUM_CMP; i++) begin
                if (addr_i == CFG_AW'(2 * i)) begin
                    st_d.cmp[i].value = wdata_i;
                end
                if (addr_i == CFG_AW'(2 * i + 1)) begin
                    st_d.cmp[i].kind   = wdata_i[2:0];
                    st_d.cmp[i].acc    = wdata_i[4:3];
                    st_d.cmp[i].size   = wdata_i[6:5];
                    st_d.cmp[i].mask   = wdata_i[11:7];
                    st_d.cmp[i].l0_en  = wdata_i[12];
                    st_d.cmp[i].l0_idx = wdata_i[15:13];
                    st_d.cmp[i].l1_en  = wdata_i[16];
                    st_d.cmp[i].l1_idx = wdata_i[19:17];
                end
            end
            if (addr_i == CFG_AW'(TRIG_IDX)) begin
                st_d.trig = unpack_evt(wdata_i);
            end
            if (addr_i == CFG_AW'(ENAB_IDX)) begin
                st_d.enab = unpack_evt(wdata_i);
            end
            if (addr_i == CFG_AW'(LATCH_IDX)) begin
                st_d.set_m = wdata_i[NUM_CMP-1:0];
                st_d.clr_m = wdata_i[CLR_LSB +: NUM_CMP];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp_cfg_o  = st_q.cmp;
    assign trig_cfg_o = st_q.trig;
    assign enab_cfg_o = st_q.enab;
    assign set_mask_o = st_q.set_m;
    assign clr_mask_o = st_q.clr_m;

endmodule

// File: rtl/wpt_comparator.sv
module wpt_comparator
    import wpt_pkg::*;
#(
    parameter int CYC_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] value_i,
    input  logic [2:0]        kind_i,
    input  logic [1:0]        acc_i,
    input  logic [1:0]        size_i,
    input  logic [MASK_W-1:0] mask_i,
    input  logic              pc_valid_i,
    input  logic [WORD_W-1:0] pc_i,
    input  logic              bus_valid_i,
    input  logic              bus_write_i,
    input  logic [1:0]        bus_size_i,
    input  logic [WORD_W-1:0] bus_addr_i,
    input  logic [WORD_W-1:0] bus_data_i,
    input  logic [CYC_W-1:0]  cyc_i,
    input  logic              link_ok_i,
    output logic              addr_hit_o,
    output logic              hit_o,
    output logic              match_o
);

    typedef struct packed {
        logic match;
    } cmp_st_t;

    cmp_st_t st_d, st_q;

    logic [MASK_W-1:0] shamt;
    logic [WORD_W-1:0] amask;
    logic [WORD_W-1:0] vmask;
    logic              dir_ok;
    logic              i_hit;
    logic              d_hit;
    logic              v_hit;
    logic              c_hit;

    always_comb begin
        // fetches are halfword aligned: bit 0 never takes part
        shamt = mask_i;
        if (kind_i == KIND_IADDR && mask_i == '0) begin
            shamt = MASK_W'(1);
        end
        amask = {WORD_W{1'b1}} << shamt;

        unique case (acc_i)
            ACC_RD:  dir_ok = !bus_write_i;
            ACC_WR:  dir_ok = bus_write_i;
            default: dir_ok = 1'b1;
        endcase

        unique case (size_i)
            SZ_BYTE: vmask = WORD_W'(8'hFF);
            SZ_HALF: vmask = WORD_W'(16'hFFFF);
            default: vmask = {WORD_W{1'b1}};
        endcase

        i_hit = pc_valid_i && ((pc_i & amask) == (value_i & amask));
        d_hit = (kind_i == KIND_DADDR) && bus_valid_i && dir_ok
                && ((bus_addr_i & amask) == (value_i & amask));
        v_hit = bus_valid_i && dir_ok && (bus_size_i == size_i)
                && ((bus_data_i & vmask) == (value_i & vmask)) && link_ok_i;
        c_hit = (cyc_i == value_i[CYC_W-1:0]);

        unique case (kind_i)
            KIND_IADDR: hit_o = i_hit;
            KIND_DADDR: hit_o = d_hit;
            KIND_DVAL:  hit_o = v_hit;
            KIND_CYCLE: hit_o = c_hit;
            default:    hit_o = 1'b0;
        endcase

        addr_hit_o = d_hit;
        st_d.match = hit_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign match_o = st_q.match;

    assert_iaddr_needs_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == KIND_IADDR && hit_o) |-> pc_valid_i);

    assert_rdonly_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == KIND_DADDR && acc_i == ACC_RD && hit_o) |-> (bus_valid_i && !bus_write_i));

    assert_wronly_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == KIND_DADDR && acc_i == ACC_WR && hit_o) |-> (bus_valid_i && bus_write_i));

    assert_value_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == KIND_DVAL && hit_o) |-> (bus_valid_i && bus_size_i == size_i));

endmodule

// File: rtl/wpt_event_comb.sv
module wpt_event_comb
    import wpt_pkg::*;
#(
    parameter int NUM_RES = 5
) (
    input  evt_cfg_t           cfg_i,
    input  logic [NUM_RES-1:0] res_i,
    output logic               evt_o
);

    logic a_raw, b_raw, a_eff, b_eff;

    always_comb begin
        a_raw = 1'b0;
        b_raw = 1'b0;
        for (int k = 0; k < NUM_RES; k++) begin
            if (cfg_i.sel_a == SEL_W'(k)) a_raw = res_i[k];
            if (cfg_i.sel_b == SEL_W'(k)) b_raw = res_i[k];
        end
        a_eff = a_raw ^ cfg_i.inv_a;
        b_eff = b_raw ^ cfg_i.inv_b;

        unique case (cfg_i.form)
            EVT_FALSE: evt_o = 1'b0;
            EVT_TRUE:  evt_o = 1'b1;
            EVT_ONE:   evt_o = a_eff;
            default: begin
                unique case (cfg_i.op)
                    OP_AND:  evt_o = a_eff & b_eff;
                    OP_OR:   evt_o = a_eff | b_eff;
                    OP_XOR:  evt_o = a_eff ^ b_eff;
                    default: evt_o = !(a_eff & b_eff);
                endcase
            end
        endcase
    end

endmodule

// File: rtl/wpt_event_unit.sv
module wpt_event_unit
    import wpt_pkg::*;
#(
    parameter int NUM_CMP = 4,
    parameter int CYC_W   = 32,
    localparam int NUM_RES = NUM_CMP + 1,
    localparam int CFG_AW  = $clog2(2 * NUM_CMP + 3)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [WORD_W-1:0]  cfg_wdata,
    input  logic               pc_valid,
    input  logic [WORD_W-1:0]  pc,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [1:0]         bus_size,
    input  logic [WORD_W-1:0]  bus_addr,
    input  logic [WORD_W-1:0]  bus_data,
    input  logic [CYC_W-1:0]   cyc_cnt,
    output logic [NUM_CMP-1:0] cmp_match,
    output logic               latch_state,
    output logic               trig_evt,
    output logic               enab_evt
);

    cmp_cfg_t [NUM_CMP-1:0] cmp_cfg;
    evt_cfg_t               trig_cfg;
    evt_cfg_t               enab_cfg;
    logic [NUM_CMP-1:0]     set_mask;
    logic [NUM_CMP-1:0]     clr_mask;

    logic [NUM_CMP-1:0]     addr_hit;
    logic [NUM_CMP-1:0]     hit_raw;
    logic [NUM_CMP-1:0]     match_q;

    wpt_cfg_regs #(
        .NUM_CMP (NUM_CMP),
        .CFG_AW  (CFG_AW)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (cfg_we),
        .addr_i     (cfg_addr),
        .wdata_i    (cfg_wdata),
        .cmp_cfg_o  (cmp_cfg),
        .trig_cfg_o (trig_cfg),
        .enab_cfg_o (enab_cfg),
        .set_mask_o (set_mask),
        .clr_mask_o (clr_mask)
    );

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        logic lok;

        always_comb begin
            lok = !(cmp_cfg[g].l0_en || cmp_cfg[g].l1_en);
            for (int k = 0; k < NUM_CMP; k++) begin
                if (cmp_cfg[g].l0_en && cmp_cfg[g].l0_idx == IDX_W'(k) && addr_hit[k]) lok = 1'b1;
                if (cmp_cfg[g].l1_en && cmp_cfg[g].l1_idx == IDX_W'(k) && addr_hit[k]) lok = 1'b1;
            end
        end

        wpt_comparator #(
            .CYC_W (CYC_W)
        ) u_cmp (
            .clk         (clk),
            .rst_n       (rst_n),
            .value_i     (cmp_cfg[g].value),
            .kind_i      (cmp_cfg[g].kind),
            .acc_i       (cmp_cfg[g].acc),
            .size_i      (cmp_cfg[g].size),
            .mask_i      (cmp_cfg[g].mask),
            .pc_valid_i  (pc_valid),
            .pc_i        (pc),
            .bus_valid_i (bus_valid),
            .bus_write_i (bus_write),
            .bus_size_i  (bus_size),
            .bus_addr_i  (bus_addr),
            .bus_data_i  (bus_data),
            .cyc_i       (cyc_cnt),
            .link_ok_i   (lok),
            .addr_hit_o  (addr_hit[g]),
            .hit_o       (hit_raw[g]),
            .match_o     (match_q[g])
        );

        assert_linked_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (cmp_cfg[g].kind == KIND_DVAL && (cmp_cfg[g].l0_en || cmp_cfg[g].l1_en) && hit_raw[g])
            |-> (addr_hit != '0));
    end

    typedef struct packed {
        logic latch;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    set_hit;
    logic    clr_hit;

    always_comb begin
        set_hit = (hit_raw & set_mask) != '0;
        clr_hit = (hit_raw & clr_mask) != '0;
        st_d    = st_q;
        if (set_hit) begin
            st_d.latch = 1'b1;
        end else if (clr_hit) begin
            st_d.latch = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic [NUM_RES-1:0] resources;
    assign resources = {st_q.latch, match_q};

    wpt_event_comb #(.NUM_RES(NUM_RES)) u_trig (
        .cfg_i (trig_cfg),
        .res_i (resources),
        .evt_o (trig_evt)
    );

    wpt_event_comb #(.NUM_RES(NUM_RES)) u_enab (
        .cfg_i (enab_cfg),
        .res_i (resources),
        .evt_o (enab_evt)
    );

    assign cmp_match   = match_q;
    assign latch_state = st_q.latch;

    assert_latch_sets_from_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.latch) |-> $past((hit_raw & set_mask) != '0));

    assert_latch_clear_yields_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.latch) |-> $past(((hit_raw & set_mask) == '0) && ((hit_raw & clr_mask) != '0)));

    assert_false_event_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_cfg.form == EVT_FALSE) |-> !trig_evt);

endmodule

// File: tb/wpt_event_unit_tb.sv
`timescale 1ns/1ps
module wpt_event_unit_tb;

    localparam int N  = 4;
    localparam int AW = $clog2(2 * N + 3);

    logic           clk = 1'b0;
    logic           rst_n;
    logic           cfg_we;
    logic [AW-1:0]  cfg_addr;
    logic [31:0]    cfg_wdata;
    logic           pc_valid;
    logic [31:0]    pc;
    logic           bus_valid;
    logic           bus_write;
    logic [1:0]     bus_size;
    logic [31:0]    bus_addr;
    logic [31:0]    bus_data;
    logic [31:0]    cyc_cnt;
    logic [N-1:0]   cmp_match;
    logic           latch_state;
    logic           trig_evt;
    logic           enab_evt;

    always #4 clk = ~clk;

    wpt_event_unit #(.NUM_CMP(N), .CYC_W(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .pc_valid(pc_valid), .pc(pc), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_data(bus_data), .cyc_cnt(cyc_cnt),
        .cmp_match(cmp_match), .latch_state(latch_state), .trig_evt(trig_evt), .enab_evt(enab_evt)
    );

    int tests = 0;
    int fails = 0;

    // reference state
    int unsigned mv[N];
    int mk[N], macc[N], msz[N], mmask[N], ml0e[N], ml0i[N], ml1e[N], ml1i[N];
    int ef[2], esa[2], eia[2], esb[2], eib[2], eop[2];
    bit [N-1:0] mset, mclr;
    bit [N-1:0] exp_match;
    bit latch_m;

    task automatic chk(string what, string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit amatch(int unsigned a, int unsigned v, int m);
        int unsigned msk = 32'hFFFF_FFFF << m;
        return (a & msk) == (v & msk);
    endfunction

    function automatic bit dir_ok(int mode);
        if (mode == 1) return !bus_write;
        if (mode == 2) return bus_write;
        return 1'b1;
    endfunction

    function automatic bit d_hit(int i);
        return mk[i] == 2 && bus_valid && dir_ok(macc[i]) && amatch(bus_addr, mv[i], mmask[i]);
    endfunction

    function automatic bit raw(int i);
        int unsigned vm;
        bit linked;
        case (mk[i])
            1: return pc_valid && amatch(pc, mv[i], (mmask[i] == 0) ? 1 : mmask[i]);
            2: return d_hit(i);
            3: begin
                vm = (msz[i] == 0) ? 32'hFF : (msz[i] == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
                linked = !(ml0e[i] != 0 || ml1e[i] != 0);
                if (ml0e[i] != 0 && ml0i[i] < N && d_hit(ml0i[i])) linked = 1;
                if (ml1e[i] != 0 && ml1i[i] < N && d_hit(ml1i[i])) linked = 1;
                return bus_valid && dir_ok(macc[i]) && bus_size == msz[i]
                       && ((bus_data & vm) == (mv[i] & vm)) && linked;
            end
            4: return cyc_cnt == mv[i];
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit resv(int s);
        if (s < N) return exp_match[s];
        if (s == N) return latch_m;
        return 1'b0;
    endfunction

    function automatic bit evt(int e);
        bit a, b;
        a = resv(esa[e]) ^ eia[e][0];
        b = resv(esb[e]) ^ eib[e][0];
        case (ef[e])
            0: return 1'b0;
            1: return 1'b1;
            2: return a;
            default: case (eop[e])
                0: return a & b;
                1: return a | b;
                2: return a ^ b;
                default: return !(a & b);
            endcase
        endcase
    endfunction

    task automatic apply_write(int a, int unsigned d);
        if (a < 2 * N) begin
            if (a % 2 == 0) mv[a / 2] = d;
            else begin
                mk[a/2] = d & 7; macc[a/2] = (d >> 3) & 3; msz[a/2] = (d >> 5) & 3;
                mmask[a/2] = (d >> 7) & 31; ml0e[a/2] = (d >> 12) & 1; ml0i[a/2] = (d >> 13) & 7;
                ml1e[a/2] = (d >> 16) & 1; ml1i[a/2] = (d >> 17) & 7;
            end
        end else if (a == 2 * N || a == 2 * N + 1) begin
            int e = a - 2 * N;
            ef[e] = d & 3; esa[e] = (d >> 2) & 15; eia[e] = (d >> 6) & 1;
            esb[e] = (d >> 7) & 15; eib[e] = (d >> 11) & 1; eop[e] = (d >> 12) & 3;
        end else if (a == 2 * N + 2) begin
            mset = d[N-1:0];
            mclr = d[8 +: N];
        end
    endtask

    // one clock: predict, let the edge pass, compare away from the edge
    task automatic step(string req);
        bit [N-1:0] nxt;
        bit ln;
        for (int i = 0; i < N; i++) nxt[i] = raw(i);
        ln = latch_m;
        if ((nxt & mset) != 0) ln = 1;
        else if ((nxt & mclr) != 0) ln = 0;
        if (cfg_we) apply_write(int'(cfg_addr), cfg_wdata);
        @(negedge clk);
        exp_match = nxt;
        latch_m = ln;
        cfg_we = 1'b0;
        cyc_cnt = cyc_cnt + 1;
        chk("cmp_match", req, int'(cmp_match), int'(exp_match));
        chk("latch_state", "R10", int'(latch_state), int'(latch_m));
        chk("trig_evt", (ef[0] == 3) ? "R9" : "R8", int'(trig_evt), int'(evt(0)));
        chk("enab_evt", (ef[1] == 3) ? "R9" : "R8", int'(enab_evt), int'(evt(1)));
    endtask

    task automatic wr(int a, int unsigned d);
        pc_valid = 0; bus_valid = 0;
        cfg_we = 1; cfg_addr = AW'(a); cfg_wdata = d;
        step("R11");
    endtask

    task automatic fetch(int unsigned p, string req);
        pc_valid = 1; pc = p; bus_valid = 0;
        step(req);
        pc_valid = 0;
    endtask

    task automatic acc(bit w, int unsigned a, int unsigned d, int s, string req);
        pc_valid = 0; bus_valid = 1; bus_write = w; bus_addr = a; bus_data = d; bus_size = 2'(s);
        step(req);
        bus_valid = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 0; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0; pc_valid = 0; pc = '0;
        bus_valid = 0; bus_write = 0; bus_size = '0; bus_addr = '0; bus_data = '0; cyc_cnt = '0;
        for (int i = 0; i < N; i++) begin
            mv[i] = 0; mk[i] = 0; macc[i] = 0; msz[i] = 0; mmask[i] = 0;
            ml0e[i] = 0; ml0i[i] = 0; ml1e[i] = 0; ml1i[i] = 0;
        end
        for (int e = 0; e < 2; e++) begin
            ef[e] = 0; esa[e] = 0; eia[e] = 0; esb[e] = 0; eib[e] = 0; eop[e] = 0;
        end
        mset = 0; mclr = 0; exp_match = 0; latch_m = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("cmp_match", "R1", int'(cmp_match), 0);
        chk("latch_state", "R1", int'(latch_state), 0);
        chk("trig_evt", "R1", int'(trig_evt), 0);
        chk("enab_evt", "R1", int'(enab_evt), 0);
        bus_valid = 1; bus_addr = 0; bus_data = 0; pc_valid = 1; pc = 0;
        step("R1");
        step("R7");
        bus_valid = 0; pc_valid = 0;

        // R2: exact fetch address, bit 0 ignored
        wr(0, 32'h1000); wr(1, 1); wr(2 * N, 32'h2);
        fetch(32'h1000, "R2"); fetch(32'h1001, "R2"); fetch(32'h1002, "R2");
        pc = 32'h1000; step("R2");

        // R3: masked window of 16 bytes
        wr(0, 32'h2000); wr(1, 1 | (4 << 7));
        fetch(32'h200E, "R3"); fetch(32'h2010, "R3"); fetch(32'h1FFE, "R3"); fetch(32'h2000, "R3");

        // R4: direction filters, value ignored
        wr(2, 32'h4000); wr(3, 2 | (1 << 3));
        wr(4, 32'h4004); wr(5, 2 | (2 << 3));
        acc(0, 32'h4000, 32'hDEAD, 2, "R4"); acc(1, 32'h4000, 32'h0, 2, "R4");
        acc(1, 32'h4004, 32'h55, 0, "R4"); acc(0, 32'h4004, 32'h55, 0, "R4");
        acc(0, 32'h4008, 32'h55, 2, "R4");
        wr(5, 2 | (2 << 3) | (3 << 7));
        acc(1, 32'h4006, 32'h1, 1, "R3");

        // R5/R6: byte value linked to both address comparators
        wr(5, 2 | (2 << 3));
        wr(6, 32'hFF); wr(7, 3 | (1 << 12) | (1 << 13) | (1 << 16) | (2 << 17));
        acc(1, 32'h4004, 32'h12FF, 0, "R6"); acc(0, 32'h4000, 32'hFF, 0, "R6");
        acc(1, 32'h4000, 32'hFF, 0, "R6"); acc(1, 32'h4004, 32'h1FE, 0, "R6");
        acc(0, 32'h5000, 32'hFF, 0, "R6"); acc(0, 32'h4000, 32'hFF, 1, "R5");
        wr(6, 32'h1234); wr(7, 3 | (1 << 5));
        acc(1, 32'h9000, 32'hAB1234, 1, "R5"); acc(1, 32'h9000, 32'hAB1234, 2, "R5");
        acc(0, 32'h9000, 32'h1235, 1, "R5");
        wr(7, 3 | (2 << 5) | (1 << 3));
        wr(6, 32'hCAFE_0001);
        acc(0, 32'h1, 32'hCAFE_0001, 2, "R5"); acc(1, 32'h1, 32'hCAFE_0001, 2, "R5");

        // R7: cycle match and idle kinds
        wr(0, cyc_cnt + 3); wr(1, 4);
        for (int k = 0; k < 5; k++) step("R7");
        wr(1, 6); fetch(32'h1000, "R7");

        // R8/R9: event forms, inversion, operations
        wr(0, 32'h1000); wr(1, 1);
        for (int op = 0; op < 4; op++) begin
            for (int inv = 0; inv < 4; inv++) begin
                wr(2 * N + 1, 3 | (0 << 2) | ((inv & 1) << 6) | (1 << 7) | ((inv >> 1) << 11) | (op << 12));
                for (int pat = 0; pat < 4; pat++) begin
                    pc_valid = pat[0]; pc = 32'h1000;
                    bus_valid = pat[1]; bus_write = 0; bus_addr = 32'h4000; bus_size = 2;
                    step("R9");
                end
                pc_valid = 0; bus_valid = 0; step("R9");
            end
        end
        wr(2 * N, 1); step("R8");
        wr(2 * N, 2 | (9 << 2) | (1 << 6)); step("R8");
        wr(2 * N, 2 | (0 << 2) | (1 << 6)); fetch(32'h1000, "R8"); step("R8");

        // R10: set/clear latch with set priority
        wr(2 * N, 2 | (N << 2));
        wr(2 * N + 2, 1 | (2 << 8));
        fetch(32'h1000, "R10"); step("R10");
        acc(0, 32'h4000, 0, 2, "R10"); step("R10");
        pc_valid = 1; pc = 32'h1000; bus_valid = 1; bus_write = 0; bus_addr = 32'h4000;
        step("R10"); pc_valid = 0; step("R10");
        acc(0, 32'h4000, 0, 2, "R10");
        wr(2 * N + 2, 1 | (1 << 8));
        fetch(32'h1000, "R10"); fetch(32'h1000, "R10"); step("R10");

        // R11: long random mix compared every cycle
        for (int c = 0; c < 1500; c++) begin
            int i = $urandom % N;
            if ($urandom % 8 == 0) begin
                int a = $urandom % (2 * N + 3);
                int unsigned d = $urandom;
                if (a < 2 * N && a % 2 == 0) d = 32'h4000 + ($urandom % 16);
                else if (a < 2 * N) d = d & 32'h000F_F87F | (($urandom % 4) << 7);
                else d = d & 32'h0000_FFFF;
                wr(a, d);
            end else begin
                pc_valid = $urandom % 2;
                pc = ($urandom % 2) ? (mv[i] ^ ($urandom % 8)) : $urandom;
                bus_valid = $urandom % 2;
                bus_write = $urandom % 2;
                bus_size = 2'($urandom % 4);
                bus_addr = ($urandom % 2) ? (mv[i] ^ ($urandom % 4)) : $urandom;
                bus_data = ($urandom % 2) ? mv[$urandom % N] : $urandom;
                step("R11");
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule